// File: doc/BRIEF.md
# Infrared run-length sampler

This block watches one consumer-infrared receiver line and turns it into a stream of one-byte run-length codes. The line first passes through a two-flop synchronizer and an optional polarity inversion. It is then sampled once every `TICK_DIV` reference clocks, which is 64 by default: an 8 MHz reference gives an 8 µs sample. Each stretch of constant level becomes one byte. Bit 7 of the byte carries the level, and bits 6:0 carry the number of samples minus one. The bytes are pushed one per cycle into a downstream FIFO.

Short excursions are treated as glitches. A run no longer than the programmable noise threshold is absorbed into the run around it. When the line has sat at the space level for longer than the programmable idle threshold, the block flushes the idle run once and raises a packet-end pulse. It then stays silent until the next active sample. Runs longer than 128 samples are split into full-length bytes followed by a remainder byte.

Top module: `ir_runlen_sampler`

## Requirements
- R1: One sample is taken every `TICK_DIV` clocks (default 64). A level held for N·`TICK_DIV` clocks counts as exactly N samples.
- R2: Every pushed byte has the level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0.
- R3: When `invertPol` is 1, the synchronized line is inverted before sampling, so a low raw line counts as pulse.
- R4: The noise threshold is `sampleCfg[7:2]`. A run of length at most this value is merged into the run around it and is never emitted alone. With threshold 0, a single-sample run is emitted.
- R5: A run of more than 128 samples is emitted as bytes with count 127 for each complete 128 samples, followed by a byte with the remainder. A run of exactly 128 samples gives one byte with count 127 and no zero-length byte.
- R6: The idle threshold is `sampleCfg[15:8]`. When a space run reaches idle threshold + 1 samples, one byte is pushed with bit 7 = 0 and count = samples − 1. `pktEnd` is high in the same cycle as that byte.
- R7: After enable and after each packet end, nothing is emitted until a pulse sample arrives. That sample begins a new pulse run.
- R8: Sampling runs only while `globalEn` = 1, `rxEn` = 1 and `modeSel` = 2'b11. Otherwise nothing is pushed, and all run state is discarded.
- R9: Consecutive bytes alternate in level, except directly after a byte with count 127.
- R10: `pushValid` is a single-cycle strobe and is never high in two adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irRaw | input | 1 | Raw receiver line, asynchronous |
| globalEn | input | 1 | Block enable |
| rxEn | input | 1 | Receive enable |
| modeSel | input | 2 | Operating mode; 2'b11 selects receive |
| invertPol | input | 1 | Invert line polarity before sampling |
| sampleCfg | input | 14 ([15:2]) | [7:2] noise threshold, [15:8] idle threshold |
| pushValid | output | 1 | Byte push strobe toward the FIFO |
| pushData | output | 8 | Level (bit 7) and length − 1 (bits 6:0) |
| pktEnd | output | 1 | Packet-end pulse, coincident with the idle flush byte |

## Verification
Splitting a long run into 128-sample bytes and closing the run at a level change can land on the same sample count. A pulse held for exactly 128 samples makes the chunk byte and the end of the run coincide. This is provoked directly, and the bench expects a single count-127 byte followed straight away by the space flush, with no zero-length byte in between. The idle flush and packet end must also share one cycle. That pairing is judged on every flush byte, both in the captured stream and by a property.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam int NOISE_W = 6;
  localparam int IDLE_W  = 8;
  localparam logic [1:0] MODE_IR_RX = 2'b11;

  typedef enum logic {ST_WAIT, ST_RUN} rlState_e;

  typedef struct packed {
    logic clearAll;
    logic startPulse;
    logic step;
    logic commit;
    logic emitFlush;
    logic emitChunk;
  } rlStrobe_t;

  typedef struct packed {
    logic sampleHigh;
    logic pendFull;
    logic idleDue;
    logic chunkDue;
  } rlFlag_t;
endpackage

// File: rtl/ir_rl_front.sv
module ir_rl_front #(
  parameter int TICK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irRaw,
  input  logic invertPol,
  input  logic runEn,
  output logic sampleTick,
  output logic sampleLvl
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [1:0] syncQ;
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b00;
    else        syncQ <= {syncQ[0], irRaw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                divCnt <= '0;
    else if (!runEn)           divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end

  assign sampleTick = runEn && (divCnt == DIV_LAST);
  assign sampleLvl  = syncQ[1] ^ invertPol;
endmodule

// File: rtl/ir_rl_ctrl.sv
module ir_rl_ctrl import ir_rl_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      runEn,
  input  logic      sampleTick,
  input  rlFlag_t   flags,
  output rlStrobe_t stb
);
  rlState_e state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (!runEn) begin
      stb.clearAll = 1'b1;
      stateNext    = ST_WAIT;
    end else if (sampleTick) begin
      if (state == ST_WAIT) begin
        if (flags.sampleHigh) begin
          stb.startPulse = 1'b1;
          stateNext      = ST_RUN;
        end
      end else begin
        stb.step = 1'b1;
        if (flags.pendFull) begin
          stb.commit = 1'b1;
        end else if (flags.idleDue) begin
          stb.emitFlush = 1'b1;
          stateNext     = ST_WAIT;
        end else if (flags.chunkDue) begin
          stb.emitChunk = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= stateNext;
  end
endmodule

// File: rtl/ir_rl_datapath.sv
module ir_rl_datapath import ir_rl_pkg::*; #(
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rlStrobe_t          stb,
  input  logic               sampleLvl,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  output rlFlag_t            flags,
  output logic               pushValid,
  output logic [CNT_W:0]     pushData,
  output logic               pktEnd
);
  localparam int RUN_W   = CNT_W + 2;
  localparam int PEND_W  = NOISE_W + 1;
  localparam int SPACE_W = IDLE_W + 1;
  localparam logic [RUN_W-1:0] CHUNK_LEN = RUN_W'(1 << CNT_W);
  localparam logic [CNT_W-1:0] FULL_CODE = '1;

  logic               curLvl;
  logic [RUN_W-1:0]   runCnt, runNext, oldLen;
  logic [PEND_W-1:0]  pendCnt, pendNext;
  logic [SPACE_W-1:0] spaceCnt, spaceNext;
  logic               diff;
  logic [CNT_W-1:0]   commitCode, flushCode;

  always_comb begin
    diff     = (sampleLvl != curLvl);
    pendNext = diff ? pendCnt + 1'b1 : '0;
    runNext  = runCnt + 1'b1;
    oldLen   = runNext - RUN_W'(pendNext);
    if (curLvl)                 spaceNext = '0;
    else if (spaceCnt == '1)    spaceNext = spaceCnt;
    else                        spaceNext = spaceCnt + 1'b1;
    commitCode = CNT_W'(oldLen - 1'b1);
    flushCode  = (runNext >= CHUNK_LEN) ? FULL_CODE : CNT_W'(runNext - 1'b1);
    flags.sampleHigh = sampleLvl;
    flags.pendFull   = diff && (pendNext > {1'b0, noiseThr});
    flags.idleDue    = !curLvl && !diff && (spaceNext > {1'b0, idleThr});
    flags.chunkDue   = !diff && (runNext >= CHUNK_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curLvl    <= 1'b0;
      runCnt    <= '0;
      pendCnt   <= '0;
      spaceCnt  <= '0;
      pushValid <= 1'b0;
      pushData  <= '0;
      pktEnd    <= 1'b0;
    end else begin
      pushValid <= 1'b0;
      pktEnd    <= 1'b0;
      if (stb.clearAll) begin
        curLvl   <= 1'b0;
        runCnt   <= '0;
        pendCnt  <= '0;
        spaceCnt <= '0;
      end else if (stb.startPulse) begin
        curLvl   <= 1'b1;
        runCnt   <= RUN_W'(1);
        pendCnt  <= '0;
        spaceCnt <= '0;
      end else if (stb.step) begin
        if (stb.commit) begin
          if (oldLen != '0) begin
            pushValid <= 1'b1;
            pushData  <= {curLvl, commitCode};
          end
          curLvl   <= ~curLvl;
          runCnt   <= RUN_W'(pendNext);
          pendCnt  <= '0;
          spaceCnt <= curLvl ? SPACE_W'(pendNext) : '0;
        end else if (stb.emitFlush) begin
          pushValid <= 1'b1;
          pushData  <= {1'b0, flushCode};
          pktEnd    <= 1'b1;
          runCnt    <= '0;
          pendCnt   <= '0;
          spaceCnt  <= '0;
        end else if (stb.emitChunk) begin
          pushValid <= 1'b1;
          pushData  <= {curLvl, FULL_CODE};
          runCnt    <= runNext - CHUNK_LEN;
          pendCnt   <= pendNext;
          spaceCnt  <= spaceNext;
        end else begin
          runCnt   <= runNext;
          pendCnt  <= pendNext;
          spaceCnt <= spaceNext;
        end
      end
    end
  end
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler import ir_rl_pkg::*; #(
  parameter int TICK_DIV = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irRaw,
  input  logic        globalEn,
  input  logic        rxEn,
  input  logic [1:0]  modeSel,
  input  logic        invertPol,
  input  logic [15:2] sampleCfg,
  output logic        pushValid,
  output logic [7:0]  pushData,
  output logic        pktEnd
);
  logic      runEn, sampleTick, sampleLvl;
  rlStrobe_t stb;
  rlFlag_t   flags;

  assign runEn = globalEn && rxEn && (modeSel == MODE_IR_RX);

  ir_rl_front #(.TICK_DIV(TICK_DIV)) u_front (
    .clk(clk), .rst_n(rst_n), .irRaw(irRaw), .invertPol(invertPol),
    .runEn(runEn), .sampleTick(sampleTick), .sampleLvl(sampleLvl)
  );

  ir_rl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .sampleTick(sampleTick),
    .flags(flags), .stb(stb)
  );

  ir_rl_datapath #(.CNT_W(7)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sampleLvl(sampleLvl),
    .noiseThr(sampleCfg[7:2]), .idleThr(sampleCfg[15:8]), .flags(flags),
    .pushValid(pushValid), .pushData(pushData), .pktEnd(pktEnd)
  );
endmodule

// File: rtl/ir_rl_checker.sv
module ir_rl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       globalEn,
  input logic       rxEn,
  input logic [1:0] modeSel,
  input logic       pushValid,
  input logic [7:0] pushData,
  input logic       pktEnd
);
  logic gateOn, afterPkt, haveLast, lastLvl, lastFull;

  assign gateOn = globalEn && rxEn && (modeSel == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afterPkt <= 1'b0;
      haveLast <= 1'b0;
      lastLvl  <= 1'b0;
      lastFull <= 1'b0;
    end else begin
      if (pktEnd) afterPkt <= 1'b1;
      else if (pushValid) afterPkt <= 1'b0;
      if (!gateOn) begin
        haveLast <= 1'b0;
      end else if (pushValid) begin
        haveLast <= 1'b1;
        lastLvl  <= pushData[7];
        lastFull <= (pushData[6:0] == 7'h7F);
      end
    end
  end

  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gateOn |=> !pushValid); // R8
  AST_PKT_WITH_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    pktEnd |-> (pushValid && !pushData[7])); // R6
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pushValid |=> !pushValid); // R10
  AST_WAKE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && !pktEnd && afterPkt) |-> pushData[7]); // R7
  AST_LEVEL_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && haveLast && !lastFull) |-> (pushData[7] != lastLvl)); // R9
endmodule

bind ir_runlen_sampler ir_rl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .rxEn(rxEn),
  .modeSel(modeSel), .pushValid(pushValid), .pushData(pushData), .pktEnd(pktEnd)
);

// File: tb/ir_runlen_sampler_tb.sv
module ir_runlen_sampler_tb;
  localparam int TICK = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irRaw = 1'b0;
  logic        globalEn = 1'b0;
  logic        rxEn = 1'b0;
  logic [1:0]  modeSel = 2'b11;
  logic        invertPol = 1'b0;
  logic [15:2] sampleCfg = '0;
  logic        pushValid;
  logic [7:0]  pushData;
  logic        pktEnd;

  int checks = 0;
  int fails = 0;
  int gotCnt = 0;
  int adjacent = 0;
  int cycles = 0;
  logic [7:0] gotData [0:255];
  logic       gotPkt  [0:255];
  logic       prevPush = 1'b0;

  always #2.5 clk = ~clk;

  ir_runlen_sampler #(.TICK_DIV(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .irRaw(irRaw), .globalEn(globalEn), .rxEn(rxEn),
    .modeSel(modeSel), .invertPol(invertPol), .sampleCfg(sampleCfg),
    .pushValid(pushValid), .pushData(pushData), .pktEnd(pktEnd)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (pushValid) begin
      if (gotCnt < 256) begin
        gotData[gotCnt] = pushData;
        gotPkt[gotCnt]  = pktEnd;
      end
      gotCnt = gotCnt + 1;
      if (prevPush) adjacent = adjacent + 1;
    end
    prevPush = pushValid;
  end

  function automatic logic [15:2] mkCfg(int noise, int idle);
    logic [15:0] w;
    w = 16'((idle << 8) | (noise << 2));
    return w[15:2];
  endfunction

  task automatic hold(bit pulse, int n);
    irRaw = pulse ^ invertPol;
    repeat (n * TICK) @(negedge clk);
  endtask

  task automatic checkByte(int base, int k, bit lvl, int cnt, bit pkt, string tag);
    int idx;
    logic [7:0] exp;
    idx = base + k;
    exp = {lvl, 7'(cnt)};
    checks++;
    if (idx >= gotCnt) begin
      fails++;
      $display("FAIL %s: byte %0d missing, got %0d bytes, expected %02h", tag, k, gotCnt - base, exp);
    end else if (gotData[idx] !== exp || gotPkt[idx] !== pkt) begin
      fails++;
      $display("FAIL %s: byte %0d actual %02h pkt %0b, expected %02h pkt %0b",
               tag, k, gotData[idx], gotPkt[idx], exp, pkt);
    end
  endtask

  task automatic checkCount(int base, int n, string tag);
    checks++;
    if (gotCnt - base != n) begin
      fails++;
      $display("FAIL %s: byte count actual %0d expected %0d", tag, gotCnt - base, n);
    end
  endtask

  // R7: enabled with a quiet line, nothing is emitted before the first pulse
  task automatic tWaitFirst();
    int b = gotCnt;
    hold(0, 6);
    checkCount(b, 0, "R7 quiet before first pulse");
  endtask

  // R1 R2 R6: plain pattern, counts of samples minus one
  task automatic tBasic();
    int b = gotCnt;
    hold(1, 10); hold(0, 5); hold(1, 3); hold(0, 30);
    checkCount(b, 4, "R1 basic");
    checkByte(b, 0, 1, 9, 0, "R1 R2 pulse 10");
    checkByte(b, 1, 0, 4, 0, "R2 space 5");
    checkByte(b, 2, 1, 2, 0, "R2 pulse 3");
    checkByte(b, 3, 0, 20, 1, "R6 idle flush");
  endtask

  // R4: glitches at or below the threshold merge, field in bits 7:2
  task automatic tNoise();
    int b = gotCnt;
    hold(1, 10); hold(0, 1); hold(1, 5); hold(0, 25);
    checkCount(b, 2, "R4 space glitch");
    checkByte(b, 0, 1, 15, 0, "R4 merged pulse");
    checkByte(b, 1, 0, 20, 1, "R4 flush");
    b = gotCnt;
    hold(1, 4); hold(0, 8); hold(1, 1); hold(0, 25);
    checkCount(b, 2, "R4 pulse glitch");
    checkByte(b, 0, 1, 3, 0, "R4 pulse before glitch");
    checkByte(b, 1, 0, 20, 1, "R4 glitch counted in idle");
    sampleCfg = mkCfg(0, 20);
    b = gotCnt;
    hold(1, 4); hold(0, 1); hold(1, 2); hold(0, 25);
    checkCount(b, 4, "R4 threshold zero");
    checkByte(b, 1, 0, 0, 0, "R4 single sample run");
    checkByte(b, 2, 1, 1, 0, "R4 run after single");
    sampleCfg = mkCfg(1, 20);
  endtask

  // R5: long runs split; exactly 128 gives no empty byte
  task automatic tChunk();
    int b = gotCnt;
    hold(1, 300); hold(0, 25);
    checkCount(b, 4, "R5 run 300");
    checkByte(b, 0, 1, 127, 0, "R5 chunk 1");
    checkByte(b, 1, 1, 127, 0, "R5 chunk 2");
    checkByte(b, 2, 1, 43, 0, "R5 remainder");
    checkByte(b, 3, 0, 20, 1, "R6 after chunks");
    b = gotCnt;
    hold(1, 128); hold(0, 25);
    checkCount(b, 2, "R5 run 128");
    checkByte(b, 0, 1, 127, 0, "R5 exact 128");
    checkByte(b, 1, 0, 20, 1, "R5 no empty byte");
  endtask

  // R3: inverted receiver
  task automatic tInvert();
    int b;
    irRaw = 1'b1; invertPol = 1'b1;
    repeat (4 * TICK) @(negedge clk);
    b = gotCnt;
    hold(1, 6); hold(0, 25);
    checkCount(b, 2, "R3 inverted");
    checkByte(b, 0, 1, 5, 0, "R3 low raw is pulse");
    checkByte(b, 1, 0, 20, 1, "R3 flush");
    irRaw = 1'b0; invertPol = 1'b0;
    repeat (4 * TICK) @(negedge clk);
  endtask

  // R6 R7: idle field in bits 15:8, silence after packet end
  task automatic tIdle();
    int b = gotCnt;
    sampleCfg = mkCfg(1, 5);
    hold(1, 3); hold(0, 10);
    checkCount(b, 2, "R6 short idle");
    checkByte(b, 0, 1, 2, 0, "R6 pulse");
    checkByte(b, 1, 0, 5, 1, "R6 flush at idle+1");
    b = gotCnt;
    hold(0, 40);
    checkCount(b, 0, "R7 silent after packet end");
    sampleCfg = mkCfg(1, 20);
  endtask

  // R8: gating
  task automatic tGate();
    int b = gotCnt;
    modeSel = 2'b01;
    hold(1, 10); hold(0, 30);
    checkCount(b, 0, "R8 wrong mode");
    modeSel = 2'b11; rxEn = 1'b0;
    hold(1, 10); hold(0, 30);
    checkCount(b, 0, "R8 receive disabled");
    rxEn = 1'b1;
    hold(1, 10);
    globalEn = 1'b0;
    hold(0, 5);
    checkCount(b, 0, "R8 disabled mid run");
    globalEn = 1'b1;
    hold(0, 3);
    hold(1, 4); hold(0, 25);
    checkCount(b, 2, "R8 fresh after enable");
    checkByte(b, 0, 1, 3, 0, "R8 stale run dropped");
  endtask

  initial begin
    sampleCfg = mkCfg(1, 20);
    repeat (5) @(negedge clk);
    checks++;
    if (pushValid !== 1'b0 || pktEnd !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: pushValid %0b pktEnd %0b expected 0 0", pushValid, pktEnd);
    end
    rst_n = 1'b1;
    globalEn = 1'b1; rxEn = 1'b1; modeSel = 2'b11;
    tWaitFirst();
    tBasic();
    tNoise();
    tChunk();
    tInvert();
    tIdle();
    tGate();
    checks++;
    if (adjacent != 0) begin
      fails++;
      $display("FAIL R10: adjacent pushes actual %0d expected 0", adjacent);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: cycles %0d expected completion", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule